// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of an integer-N frequency synthesizer, after a dual-modulus prescaler. It runs on the prescaler's output clock. It steers the prescaler's modulus-control line so that the prescaler divides by P+1 for the first A of its output periods in each divide cycle and by P for the remaining B−A periods. Each divide cycle is therefore B prescaler periods long and spans B·P + A cycles of the oscillator. The block emits one pulse per divide cycle toward the phase detector.

A swallow count (A, 6 bits) and a main count (B, 13 bits) are presented together with a load strobe. A loaded pair is clamped into the legal range and held as pending. It only replaces the working pair when the cycle in progress ends, so no divide cycle ever mixes two settings. The block itself never sees P. The prescaler applies P, and the block only tells it which modulus to use for the coming period.

Top module: `psw_divider`

## Requirements
- R1: With reset held (synchronous, active high, sampled on the prescaler clock), the working pair becomes A=0, B=3. After release, `mc_o`, `div_o` and `cfg_bad_o` are 0 and the first full divide cycles use that pair.
- R2: Every divide cycle lasts exactly B rising edges of `pre_clk_i`. `div_o` is 1 for exactly one prescaler period, the last one of the cycle, and the cycle ends at the edge that closes that period.
- R3: `mc_o` = 1 requests divide-by-(P+1) and `mc_o` = 0 requests divide-by-P for the period that begins at the preceding edge. In each cycle `mc_o` is 1 for the first A periods and 0 for the rest, so a cycle covers B·P + A oscillator cycles.
- R4: With A=0, `mc_o` stays 0 for the whole cycle. With A=B, it stays 1 for the whole cycle.
- R5: A pair sampled with `load_i` = 1 during a cycle takes effect from the next cycle. The cycle in progress finishes with its old pair.
- R6: If `load_i` is sampled on the edge that ends a cycle, the new pair does not apply to the cycle that starts at that edge. It applies from the cycle after it.
- R7: A loaded B below 3 is raised to 3. A loaded A above the (raised) B is lowered to that B. `cfg_bad_o` goes to 1 after a load whose raw values had B < 3 or A > B, and to 0 after a load with legal values. It holds between loads.
- R8: When several loads occur within one cycle, the last one decides the pair used in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk_i | input | 1 | Prescaler output clock; every rising edge ends one prescaler period |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that captures `swal_i`/`main_i` as the pending pair |
| swal_i | input | 6 | Swallow count A |
| main_i | input | 13 | Main count B |
| mc_o | output | 1 | Modulus control: 1 = divide by P+1, 0 = divide by P |
| div_o | output | 1 | Divided output, high during the last prescaler period of each cycle |
| cfg_bad_o | output | 1 | Last loaded pair was out of range and was clamped |

## Verification
The hardest case to reach is a load that lands exactly on the edge closing a divide cycle, because the strobe has to line up with a single prescaler edge. The bench watches `div_o` at the oscillator's falling edge and raises the strobe as soon as the final period begins. The strobe is therefore sampled on the terminal edge and on no other edge. A behavioural prescaler in the bench closes the loop: it really stretches periods by one oscillator cycle when `mc_o` asks for it. Each cycle is judged by its oscillator length as well as by its period and modulus counts.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int A_W   = 6;
    localparam int B_W   = 13;
    localparam int B_MIN = 3;

    typedef struct packed {
        logic [B_W-1:0] main;
        logic [A_W-1:0] swal;
    } div_cfg_t;

    localparam div_cfg_t RST_CFG = '{main: B_W'(B_MIN), swal: '0};

    function automatic logic cfg_is_bad(input div_cfg_t raw);
        return (raw.main < B_W'(B_MIN)) || (B_W'(raw.swal) > raw.main);
    endfunction

    function automatic div_cfg_t clamp_cfg(input div_cfg_t raw);
        div_cfg_t c;
        c = raw;
        if (c.main < B_W'(B_MIN))
            c.main = B_W'(B_MIN);
        if (B_W'(c.swal) > c.main)
            c.swal = A_W'(c.main);
        return c;
    endfunction

endpackage

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage
    import psw_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     load_i,
    input  div_cfg_t raw_i,
    input  logic     boundary_i,
    output div_cfg_t nxt_o,
    output logic     bad_o
);

    div_cfg_t act_q;
    div_cfg_t pend_q;
    logic     pend_v_q;
    logic     bad_q;

    assign nxt_o = pend_v_q ? pend_q : act_q;
    assign bad_o = bad_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q    <= RST_CFG;
            pend_q   <= RST_CFG;
            pend_v_q <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            if (boundary_i)
                act_q <= nxt_o;
            if (load_i) begin
                pend_q   <= clamp_cfg(raw_i);
                pend_v_q <= 1'b1;
                bad_q    <= cfg_is_bad(raw_i);
            end else if (boundary_i) begin
                pend_v_q <= 1'b0;
            end
        end
    end

    // R7: the pair offered to the counters is always inside the legal range
    p_clamped_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (nxt_o.main >= B_W'(B_MIN)) && (B_W'(nxt_o.swal) <= nxt_o.main));

    // R7: a short main count raises the flag
    p_bad_flag_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && (raw_i.main < B_W'(B_MIN))) |=> bad_o);

endmodule

// File: rtl/psw_main_ctr.sv
module psw_main_ctr
    import psw_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [B_W-1:0] init_i,
    output logic           term_o
);

    logic [B_W-1:0] cnt_q;

    assign term_o = (cnt_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= B_W'(B_MIN - 1);
        else if (term_o)
            cnt_q <= init_i - 1'b1;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // R2: terminal count reloads from the pair chosen for the next cycle
    p_reload_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        term_o |=> (cnt_q == $past(init_i) - 1'b1));

    // R2: mid-cycle edges step the count by exactly one
    p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !term_o |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/psw_swallow_ctr.sv
module psw_swallow_ctr
    import psw_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           reload_i,
    input  logic [A_W-1:0] init_i,
    output logic           mc_o
);

    logic [A_W-1:0] cnt_q;

    assign mc_o = (cnt_q != '0);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= RST_CFG.swal;
        else if (reload_i)
            cnt_q <= init_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // R3: a nonzero swallow count starts the cycle on the long modulus
    p_mc_start_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (reload_i && (init_i != '0)) |=> mc_o);

    // R3: once on the short modulus, it stays there until the next cycle
    p_mc_low_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mc_o && !reload_i) |=> !mc_o);

endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
(
    input  logic           pre_clk_i,
    input  logic           rst_i,
    input  logic           load_i,
    input  logic [A_W-1:0] swal_i,
    input  logic [B_W-1:0] main_i,
    output logic           mc_o,
    output logic           div_o,
    output logic           cfg_bad_o
);

    div_cfg_t raw;
    div_cfg_t nxt;
    logic     term;

    assign raw   = '{main: main_i, swal: swal_i};
    assign div_o = term;

    psw_cfg_stage u_cfg (
        .clk_i      (pre_clk_i),
        .rst_i      (rst_i),
        .load_i     (load_i),
        .raw_i      (raw),
        .boundary_i (term),
        .nxt_o      (nxt),
        .bad_o      (cfg_bad_o)
    );

    psw_main_ctr u_main (
        .clk_i  (pre_clk_i),
        .rst_i  (rst_i),
        .init_i (nxt.main),
        .term_o (term)
    );

    psw_swallow_ctr u_swal (
        .clk_i    (pre_clk_i),
        .rst_i    (rst_i),
        .reload_i (term),
        .init_i   (nxt.swal),
        .mc_o     (mc_o)
    );

    // R2: the divided pulse lasts a single prescaler period
    p_pulse_single_r2: assert property (@(posedge pre_clk_i) disable iff (rst_i)
        div_o |=> !div_o);

endmodule

// File: tb/psw_divider_bench.sv
module psw_divider_bench;
    import psw_pkg::*;

    localparam int P = 4;

    typedef struct {
        int    a;
        int    b;
        string tag;
    } exp_t;

    logic        vco = 1'b0;
    logic        rst_i = 1'b1;
    logic        load_i = 1'b0;
    logic [5:0]  swal_i = '0;
    logic [12:0] main_i = '0;
    logic        mc_o, div_o, cfg_bad_o;
    logic        pre_clk;
    int          pc = 0;

    int   errs = 0, chks = 0;
    exp_t q[$];
    exp_t nxt;
    exp_t held;
    int   nbound = 0, seen = 0;
    bit   stop = 0;

    always #4 vco = ~vco;   // 125 MHz oscillator

    // behavioural prescaler: period of P or P+1 oscillator cycles
    assign pre_clk = (pc == 0);
    always @(posedge vco) begin
        if (pc >= P + ((mc_o === 1'b1) ? 1 : 0) - 1) pc <= 0;
        else                                         pc <= pc + 1;
    end

    psw_divider u_psw_divider (
        .pre_clk_i (pre_clk),
        .rst_i     (rst_i),
        .load_i    (load_i),
        .swal_i    (swal_i),
        .main_i    (main_i),
        .mc_o      (mc_o),
        .div_o     (div_o),
        .cfg_bad_o (cfg_bad_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: measures each divide cycle and compares with the queue head
    int vcnt = 0, prd = 0, mcn = 0;
    bit last_f = 0, synced = 0;
    always @(negedge vco) begin
        if (!rst_i && !stop) begin
            vcnt++;
            if (pre_clk) begin
                if (last_f) begin
                    if (synced) begin
                        if (q.size() == 0) begin
                            chk(0, "R2", "scoreboard empty", 0, 1);
                        end else begin
                            exp_t e;
                            e = q.pop_front();
                            chk(prd == e.b, e.tag, "prescaler periods (R2)", prd, e.b);
                            chk(mcn == e.a, e.tag, "long-modulus periods (R3)", mcn, e.a);
                            chk(vcnt == e.b * P + e.a, e.tag, "oscillator cycles (R3)",
                                vcnt, e.b * P + e.a);
                        end
                    end
                    synced = 1;
                    vcnt = 0; prd = 0; mcn = 0;
                    nbound++;
                end
                prd++;
                if (mc_o === 1'b1) mcn++;
                last_f = (div_o === 1'b1);
            end
        end
    end

    // driver: push the expectation for the cycle that has just started
    task automatic next_cycle(input string tag);
        exp_t e;
        wait (nbound > seen);
        seen = nbound;
        e = nxt;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic load_cfg(input int a, input int b, input string tag);
        int bb;
        bit bad;
        bb  = (b < 3) ? 3 : b;
        bad = (b < 3) || (a > b);
        swal_i = 6'(a); main_i = 13'(b); load_i = 1'b1;
        @(posedge pre_clk);
        @(negedge vco);
        load_i = 1'b0;
        nxt.b = bb;
        nxt.a = (a > bb) ? bb : a;
        chk(cfg_bad_o == bad, tag, "cfg_bad_o", int'(cfg_bad_o), int'(bad));
    endtask

    // R6: strobe sampled on the edge that ends the cycle
    task automatic late_load(input int a, input int b);
        do @(negedge vco); while (div_o !== 1'b1);
        swal_i = 6'(a); main_i = 13'(b); load_i = 1'b1;
        @(posedge pre_clk);
        @(negedge vco);
        load_i = 1'b0;
        held.b = b; held.a = a; held.tag = "";
        chk(cfg_bad_o == 1'b0, "R6", "cfg_bad_o", int'(cfg_bad_o), 0);
    endtask

    initial begin
        nxt.a = 0; nxt.b = 3; nxt.tag = "";
        repeat (20) @(negedge vco);
        rst_i = 1'b0;
        // R1: state right after reset release
        chk(mc_o == 1'b0, "R1", "mc_o after reset", int'(mc_o), 0);
        chk(div_o == 1'b0, "R1", "div_o after reset", int'(div_o), 0);
        chk(cfg_bad_o == 1'b0, "R1", "cfg_bad_o after reset", int'(cfg_bad_o), 0);

        next_cycle("R1");                 // default pair A=0, B=3
        load_cfg(5, 10, "R5");
        next_cycle("R5");                 // now 5/10
        next_cycle("R2");
        load_cfg(0, 7, "R7");
        next_cycle("R4");                 // A=0
        load_cfg(9, 9, "R7");
        next_cycle("R4");                 // A=B
        load_cfg(2, 1, "R7");             // B raised to 3
        next_cycle("R7");
        load_cfg(40, 12, "R7");           // A lowered to 12
        next_cycle("R7");
        load_cfg(3, 8, "R8");
        load_cfg(1, 20, "R8");            // last load wins
        next_cycle("R8");
        late_load(4, 6);
        next_cycle("R6");                 // still 1/20
        nxt = held;
        next_cycle("R6");                 // now 4/6
        load_cfg(63, 200, "R7");
        next_cycle("R3");                 // 63/200
        wait (nbound > seen);
        stop = 1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge vco);
        errs++; chks++;
        $display("FAIL R2 watchdog expired: got 0 expected 1");
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

endmodule